// File: doc/BRIEF.md
# Receive Error Status and Event Counters

This block gathers the error strobes raised by a receive cell path and keeps them where software can find them. Seven error kinds arrive together on a per-cycle event beat: header-byte parity, header-byte CRC, header sequence number, pointer-byte parity, pointer out of range, buffer write underrun and buffer write overrun. Each kind latches a sticky status flag that software clears by writing one. A summary service bit stands above all flags.

A five-bit select mask in the control register marks which of the first five error kinds count as "miscellaneous". Each beat that carries a selected kind, or any beat while the test bit is set, bumps a 16-bit miscellaneous counter and captures bits 19:4 of the control-structure address that came with the beat. Underruns and overruns each have their own 16-bit counter. A counter that wraps from 0xFFFF to 0x0000 raises a rollover flag in the status register.

Events enter as a valid/ready beat. `ev_ready` is always high: the block takes one beat every cycle and never applies back-pressure. A cycle with `ev_valid` low carries no event, whatever `ev_kind` holds. Software uses a single-cycle write strobe. Read data is registered: `reg_rdata` shows the register addressed by `reg_addr` one clock later.

Top module: `rx_err_monitor`

## Requirements
- R1: After reset every register reads 0x0000. Status bits 4:0 always read zero, and a read of any offset outside the map returns 0x0000.
- R2: A beat with `ev_valid` high sets status bit 5+i for each set bit i of `ev_kind`. The kinds are: 0 header parity, 1 header CRC, 2 sequence number, 3 pointer parity, 4 pointer range, 5 underrun, 6 overrun.
- R3: A status flag stays set until software writes 1 to its bit at offset 0x02. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R4: Status bit 15 is set whenever any of status bits 14:5 is set. Once set, it clears only through a write of 1 to bit 15.
- R5: The miscellaneous counter (offset 0x12) increments by exactly one on a valid beat in which any `ev_kind[i]` (i in 0..4) meets control bit i set, however many such kinds coincide. Unselected kinds leave it unchanged.
- R6: While control bit 5 (test) is set, every valid beat increments the miscellaneous counter once and loads the event-ID register.
- R7: The event-ID register (offset 0x10) loads `ev_addr[19:4]` on every beat that increments the miscellaneous counter, and otherwise holds its value.
- R8: The underrun counter (offset 0x22) and the overrun counter (offset 0x32) each increment once per valid beat that carries kind 5 or kind 6 respectively.
- R9: A wrap from 0xFFFF to 0x0000 sets status bit 12 for the miscellaneous counter, bit 13 for the underrun counter and bit 14 for the overrun counter.
- R10: Software writes to the event-ID register and to the three counters take effect. A write that lands in the same cycle as an increment or a capture wins, and that increment then raises no rollover.
- R11: Control (offset 0x00) stores write-data bits 5:0 and reads back with bits 15:6 zero.
- R12: `ev_ready` is always 1. A cycle with `ev_valid` low changes no flag, counter or ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event beat present |
| ev_ready | output | 1 | Beat accepted; held at 1 |
| ev_kind | input | 7 | One strobe per error kind, encoded as in R2 |
| ev_addr | input | 20 | Address of the receive control structure for this beat |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 6 | Register byte offset for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's `reg_addr` |

## Verification
The in-line assertions check on every cycle that flags are sticky, that events set them, that the summary bit covers any set flag, and that each counter steps by exactly one or takes the written value. They also check that a wrap reaches its status bit and that the ID holds when nothing loads it. The bench's scenarios must show the mapping of each kind to its status bit and the effect of the select mask. They also cover several selected kinds counted once in one cycle, the test-bit path, same-cycle clear and write collisions, and the register map with its zero fill. These depend on the specific values software and the event stream present, so only the scenarios can exercise them.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int REG_W    = 16;
  localparam int OFF_W    = 6;
  localparam int N_KIND   = 7;
  localparam int N_MISC   = 5;
  localparam int N_CNT    = 3;
  localparam int N_FLAG   = N_KIND + N_CNT;
  localparam int FLAG_LSB = 5;
  localparam int CTRL_W   = N_MISC + 1;
  localparam int TEST_BIT = N_MISC;

  localparam int K_URUN = 5;
  localparam int K_ORUN = 6;

  localparam logic [OFF_W-1:0] OFF_CTRL = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'h02;
  localparam logic [OFF_W-1:0] OFF_ID   = 6'h10;

  typedef enum logic [1:0] {CNT_MISC = 2'd0, CNT_URUN = 2'd1, CNT_ORUN = 2'd2} cnt_sel_e;

  function automatic logic [OFF_W-1:0] cnt_off(input int k);
    return OFF_W'(8'h12 + 8'(k) * 8'h10);
  endfunction
endpackage

// File: rtl/rxerr_flags.sv
module rxerr_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         sum_clr_i,
  output logic [N-1:0] flags_o,
  output logic         sum_o
);
  logic [N-1:0] flag_q, flag_d;
  logic         sum_q, sum_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
    sum_d  = (sum_q & ~sum_clr_i) | (|flag_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      sum_q  <= sum_d;
    end
  end

  assign flags_o = flag_q;
  assign sum_o   = sum_q;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~clr_i) != '0) |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));

  assert_summary_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |-> sum_q);
endmodule

// File: rtl/rxerr_counter.sv
module rxerr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = inc_i & ~wr_i;
  assign wrap_o = step & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i)));

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rxerr_capture.sv
module rxerr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (wr_i)   val_q <= wdata_i;
    else if (load_i) val_q <= load_val_i;
  end

  assign val_o = val_q;

  assert_id_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wr_i) |=> $stable(val_q));

  assert_id_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_i) |=> (val_q == $past(load_val_i)));
endmodule

// File: rtl/rx_err_monitor.sv
module rx_err_monitor
  import rxerr_pkg::*;
#(
  parameter int EVADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [N_KIND-1:0]   ev_kind,
  input  logic [EVADDR_W-1:0] ev_addr,
  input  logic                reg_we,
  input  logic [OFF_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata
);
  localparam int ID_LSB = EVADDR_W - REG_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [N_KIND-1:0] kind_hit;
  logic              misc_hit;
  logic [N_CNT-1:0]  cnt_inc, cnt_wr, cnt_wrap;
  logic [REG_W-1:0]  cnt_val [N_CNT];
  logic [N_FLAG-1:0] flag_set, flag_clr, flags;
  logic              summary;
  logic              stat_wr, id_wr;
  logic [REG_W-1:0]  id_val;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_addr_low;

  assign ev_ready        = 1'b1;
  assign unused_addr_low = ^ev_addr[ID_LSB-1:0];

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (reg_we && reg_addr == OFF_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  // event qualification
  assign kind_hit = ev_kind & {N_KIND{ev_valid & ev_ready}};
  assign misc_hit = (|(kind_hit[N_MISC-1:0] & ctrl_q[N_MISC-1:0]))
                  | (ev_valid & ctrl_q[TEST_BIT]);

  assign cnt_inc[CNT_MISC] = misc_hit;
  assign cnt_inc[CNT_URUN] = kind_hit[K_URUN];
  assign cnt_inc[CNT_ORUN] = kind_hit[K_ORUN];

  // event counters
  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    assign cnt_wr[k] = reg_we && (reg_addr == cnt_off(k));
    rxerr_counter #(.W(REG_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (cnt_inc[k]),
      .wr_i    (cnt_wr[k]),
      .wdata_i (reg_wdata),
      .cnt_o   (cnt_val[k]),
      .wrap_o  (cnt_wrap[k])
    );

    assert_wrap_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wrap[k] |=> (flags[N_KIND+k] && summary));
  end

  // event ID capture
  assign id_wr = reg_we && reg_addr == OFF_ID;

  rxerr_capture #(.W(REG_W)) u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (misc_hit),
    .load_val_i (ev_addr[EVADDR_W-1:ID_LSB]),
    .wr_i       (id_wr),
    .wdata_i    (reg_wdata),
    .val_o      (id_val)
  );

  // status flags
  assign stat_wr  = reg_we && reg_addr == OFF_STAT;
  assign flag_set = {cnt_wrap, kind_hit};
  assign flag_clr = stat_wr ? reg_wdata[FLAG_LSB +: N_FLAG] : '0;

  rxerr_flags #(.N(N_FLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .sum_clr_i (stat_wr & reg_wdata[REG_W-1]),
    .flags_o   (flags),
    .sum_o     (summary)
  );

  // registered read port
  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFF_CTRL:   rd_mux = REG_W'(ctrl_q);
      OFF_STAT:   rd_mux = {summary, flags, {FLAG_LSB{1'b0}}};
      OFF_ID:     rd_mux = id_val;
      cnt_off(0): rd_mux = cnt_val[0];
      cnt_off(1): rd_mux = cnt_val[1];
      cnt_off(2): rd_mux = cnt_val[2];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end

  assert_unselected_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ctrl_q[TEST_BIT] && ((ev_kind[N_MISC-1:0] & ctrl_q[N_MISC-1:0]) == '0)
      && !cnt_wr[CNT_MISC]) |=> $stable(cnt_val[CNT_MISC]));

  assert_test_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ctrl_q[TEST_BIT] && !cnt_wr[CNT_MISC])
      |=> (cnt_val[CNT_MISC] == REG_W'($past(cnt_val[CNT_MISC]) + 1'b1)));

  assert_ready_high_R12: assert property (@(posedge clk) disable iff (!rst_n) ev_ready);
endmodule

// File: tb/test_rx_err_monitor.sv
`timescale 1ns/1ps
module test_rx_err_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [6:0]  ev_kind = '0;
  logic [19:0] ev_addr = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        rd_v = 1'b0, rd_v_d = 1'b0;
  logic [15:0] exp_q [$];
  logic [5:0]  adr_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  rx_err_monitor i_rx_err_monitor (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_addr(ev_addr), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic drive(input bit we, input logic [5:0] a, input logic [15:0] d,
                       input bit v, input logic [6:0] k, input logic [19:0] ea, input bit r);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    ev_valid = v; ev_kind = k; ev_addr = ea; rd_v = r;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    drive(1'b1, a, d, 1'b0, '0, '0, 1'b0);
  endtask
  task automatic ev(input logic [6:0] k, input logic [19:0] ea);
    drive(1'b0, '0, '0, 1'b1, k, ea, 1'b0);
  endtask
  task automatic evraw(input bit v, input logic [6:0] k, input logic [19:0] ea);
    drive(1'b0, '0, '0, v, k, ea, 1'b0);
  endtask
  task automatic evwr(input logic [6:0] k, input logic [19:0] ea, input logic [5:0] a, input logic [15:0] d);
    drive(1'b1, a, d, 1'b1, k, ea, 1'b0);
  endtask
  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
  endtask
  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); adr_q.push_back(a); tag_q.push_back(tag);
    drive(1'b0, a, '0, 1'b0, '0, '0, 1'b1);
  endtask

  always @(posedge clk) rd_v_d <= rd_v;

  // monitor: pops expected values as read data appears
  always @(negedge clk) begin
    if (rd_v_d && exp_q.size() > 0) begin
      logic [15:0] e; logic [5:0] a; string t;
      e = exp_q.pop_front(); a = adr_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s offset 0x%02h: actual 0x%04h expected 0x%04h", t, a, reg_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    checks++;
    if (ev_ready !== 1'b1) begin
      errors++; $display("FAIL R12 ev_ready: actual %b expected 1", ev_ready);
    end
    // R1 reset values and unmapped offset
    rd(6'h00, 16'h0000, "R1 ctrl reset");
    rd(6'h02, 16'h0000, "R1 status reset");
    rd(6'h10, 16'h0000, "R1 id reset");
    rd(6'h12, 16'h0000, "R1 misc reset");
    rd(6'h22, 16'h0000, "R1 urun reset");
    rd(6'h32, 16'h0000, "R1 orun reset");
    rd(6'h04, 16'h0000, "R1 unmapped");
    // R2 flag and R4 summary, unselected misc
    ev(7'h01, 20'h00000);
    rd(6'h02, 16'h8020, "R2 parity flag");
    rd(6'h12, 16'h0000, "R5 no select no count");
    rd(6'h10, 16'h0000, "R7 id unchanged");
    // R3/R4 clearing
    wr(6'h02, 16'h0020);
    rd(6'h02, 16'h8000, "R4 summary stays until own clear");
    wr(6'h02, 16'h8000);
    rd(6'h02, 16'h0000, "R3 cleared");
    // R5/R7 select mask
    wr(6'h00, 16'h0005);
    ev(7'h01, 20'hABCDE);
    rd(6'h12, 16'h0001, "R5 selected count");
    rd(6'h10, 16'hABCD, "R7 capture");
    ev(7'h02, 20'h12345);
    rd(6'h12, 16'h0001, "R5 unselected kind");
    rd(6'h10, 16'hABCD, "R7 unselected holds");
    ev(7'h05, 20'h55550);
    rd(6'h12, 16'h0002, "R5 two kinds count once");
    rd(6'h10, 16'h5555, "R7 capture again");
    rd(6'h02, 16'h80E0, "R2 three flags");
    // R3 event beats clear in same cycle
    evwr(7'h08, 20'h00000, 6'h02, 16'h0100);
    rd(6'h02, 16'h81E0, "R3 event wins clear");
    wr(6'h02, 16'hFFFF);
    rd(6'h02, 16'h0000, "R3 clear all");
    // R6 test bit
    wr(6'h00, 16'h0020);
    ev(7'h00, 20'h00010);
    idle();
    rd(6'h12, 16'h0003, "R6 test count");
    rd(6'h10, 16'h0001, "R6 test capture");
    ev(7'h20, 20'h00300);
    rd(6'h12, 16'h0004, "R6 test count with underrun");
    rd(6'h10, 16'h0030, "R7 capture under test");
    rd(6'h22, 16'h0001, "R8 underrun count");
    rd(6'h02, 16'h8400, "R2 underrun flag");
    // R9 misc wrap
    wr(6'h02, 16'hFFFF);
    wr(6'h12, 16'hFFFF);
    ev(7'h00, 20'h00020);
    rd(6'h12, 16'h0000, "R9 misc wrapped");
    rd(6'h02, 16'h9000, "R9 misc rollover flag");
    rd(6'h10, 16'h0002, "R6 capture on wrap");
    // R8/R9 underrun and overrun wraps
    wr(6'h00, 16'h0000);
    wr(6'h02, 16'hFFFF);
    wr(6'h22, 16'hFFFE);
    ev(7'h20, 20'h00000);
    rd(6'h22, 16'hFFFF, "R8 underrun step");
    ev(7'h20, 20'h00000);
    wr(6'h32, 16'hFFFF);
    ev(7'h40, 20'h00000);
    ev(7'h10, 20'h00000);
    rd(6'h22, 16'h0000, "R9 underrun wrapped");
    rd(6'h32, 16'h0000, "R9 overrun wrapped");
    rd(6'h02, 16'hEE00, "R9 rollover flags");
    rd(6'h12, 16'h0000, "R5 no select no count");
    // R10 write priority
    wr(6'h00, 16'h0001);
    wr(6'h02, 16'hFFFF);
    evwr(7'h40, 20'h00000, 6'h32, 16'h1234);
    rd(6'h32, 16'h1234, "R10 write beats overrun step");
    evwr(7'h01, 20'h77770, 6'h10, 16'hBEEF);
    rd(6'h10, 16'hBEEF, "R10 write beats capture");
    rd(6'h12, 16'h0001, "R5 count beside id write");
    evwr(7'h01, 20'h77770, 6'h12, 16'h0042);
    rd(6'h12, 16'h0042, "R10 write beats misc step");
    rd(6'h10, 16'h7777, "R7 capture beside count write");
    // R11 control readback, R12 invalid beat
    wr(6'h00, 16'hFFFF);
    rd(6'h00, 16'h003F, "R11 control readback");
    wr(6'h02, 16'hFFFF);
    evraw(1'b0, 7'h7F, 20'hFFFFF);
    rd(6'h02, 16'h0000, "R12 invalid beat no flag");
    rd(6'h12, 16'h0042, "R12 invalid beat no count");
    rd(6'h10, 16'h7777, "R12 invalid beat no capture");
    idle(); idle(); idle();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule